// File: doc/BRIEF.md
# Debug-Aware Trap Redirect

This block sits beside a core's trap logic. When the pipeline raises an exception, it decides where fetch restarts and which debug state changes. It looks at four things: the trap cause, the current privilege, the current PC, and the core's debug cause field. A non-zero debug cause field means the core is already halted in debug mode. The block also takes one ebreak-enable bit for each privilege level.

If the core is already in debug mode, a breakpoint sends fetch back to the debug ROM entry. Any other exception sends fetch to a separate debug exception address, and no other state changes. Outside debug mode, a breakpoint enters debug mode when the enable bit for the current privilege is set. Entry saves the PC and privilege, switches to machine mode, and records the ebreak cause. Every other trap goes to the machine trap vector and raises a normal-trap strobe.

All results are registered when the trap-valid input is high. The strobes last one cycle. The data outputs hold their values until the next trap.

Top module: `trap_redirect`

## Requirements
- R1: After reset, `next_pc_o` is RST_PC (default 0), `priv_o` and `saved_priv_o` are machine (3), `dpc_o` is 0, `dbg_cause_o` is 0, and all three strobes are low.
- R2: If `dbg_cause_i` is non-zero and the cause equals BRK_CAUSE (default 3), `next_pc_o` becomes DBG_ROM_ENTRY (default 0x800) one cycle after the trap.
- R3: If `dbg_cause_i` is non-zero and the cause is not BRK_CAUSE, `next_pc_o` becomes DBG_EXC_ADDR (default 0x808). `priv_o`, `dpc_o`, `saved_priv_o` and `dbg_cause_o` keep their values.
- R4: When `dbg_cause_i` is non-zero, neither `dbg_enter_o` nor `normal_trap_o` is raised, whatever the enable bits are.
- R5: Outside debug mode, a breakpoint whose privilege enable bit is set does all of the following one cycle later: it pulses `dbg_enter_o`, sets `next_pc_o` to DBG_ROM_ENTRY, sets `dpc_o` to the trapping PC, sets `saved_priv_o` to the trapping privilege, sets `priv_o` to machine (3), and sets `dbg_cause_o` to 1.
- R6: Bit k of `ebreak_en_i` enables debug entry for privilege encoding k (U=0, S=1, H=2, M=3). The bits for other privileges have no effect.
- R7: Outside debug mode, any other trap does the following one cycle later: it sets `next_pc_o` to `mtvec_i`, pulses `normal_trap_o`, and sets `priv_o` to machine. The debug outputs stay unchanged. This includes a breakpoint whose enable bit is clear.
- R8: `redirect_o` is high for exactly one cycle after each cycle with `trap_valid_i` high. Without `trap_valid_i`, every data output holds and the strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | An exception is raised this cycle |
| trap_cause_i | input | CAUSE_W | Exception cause code |
| priv_i | input | 2 | Current privilege (U=0, S=1, H=2, M=3) |
| pc_i | input | XLEN | PC of the trapping instruction |
| mtvec_i | input | XLEN | Machine trap vector |
| dbg_cause_i | input | DCAUSE_W | Current debug cause, non-zero in debug mode |
| ebreak_en_i | input | 4 | Ebreak-to-debug enable for each privilege |
| redirect_o | output | 1 | One-cycle pulse: `next_pc_o` is newly valid |
| next_pc_o | output | XLEN | Redirected fetch PC |
| dbg_enter_o | output | 1 | One-cycle pulse: debug mode entered |
| normal_trap_o | output | 1 | One-cycle pulse: machine trap taken |
| dpc_o | output | XLEN | Saved debug PC |
| saved_priv_o | output | 2 | Privilege saved on debug entry |
| priv_o | output | 2 | Updated current privilege |
| dbg_cause_o | output | DCAUSE_W | Updated debug cause |

## Verification
There is exactly one register between a trap and every result. The strobes and the new values therefore appear at the first rising edge after the cycle in which `trap_valid_i` is high. The bench drives each trap at a falling edge and drops it at the next falling edge. It then samples all outputs at that point, half a cycle after the register loads. One further idle cycle is sampled to confirm that the strobes have fallen and the data outputs have held. Back-to-back traps are sampled at every falling edge, so that each result is seen in its own cycle.

// File: rtl/trap_redir_pkg.sv
package trap_redir_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ACT_TRAP        = 2'd0,
    ACT_DBG_ENTER   = 2'd1,
    ACT_DBG_RESTART = 2'd2,
    ACT_DBG_EXC     = 2'd3
  } action_e;

  localparam int unsigned NUM_PRIV = 4;
  localparam int unsigned PRIV_W   = 2;
endpackage

// File: rtl/trap_redir_classify.sv
module trap_redir_classify
  import trap_redir_pkg::*;
#(
  parameter int unsigned CAUSE_W   = 4,
  parameter int unsigned DCAUSE_W  = 3,
  parameter int unsigned BRK_CAUSE = 3
) (
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [PRIV_W-1:0]   priv_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic [NUM_PRIV-1:0] ebreak_en_i,
  output action_e             act_o
);
  logic [NUM_PRIV-1:0] en_hit;
  logic                is_brk;
  logic                in_dbg;

  for (genvar gi = 0; gi < NUM_PRIV; gi++) begin : g_en
    assign en_hit[gi] = ebreak_en_i[gi] && (priv_i == PRIV_W'(gi));
  end

  assign is_brk = (cause_i == CAUSE_W'(BRK_CAUSE));
  assign in_dbg = |dbg_cause_i;

  // debug-mode check wins over ebreak enables
  always_comb begin
    if (in_dbg)                act_o = is_brk ? ACT_DBG_RESTART : ACT_DBG_EXC;
    else if (is_brk && |en_hit) act_o = ACT_DBG_ENTER;
    else                       act_o = ACT_TRAP;
  end

  always_comb begin
    a_r4_dbg_no_entry: assert (!(in_dbg && act_o inside {ACT_DBG_ENTER, ACT_TRAP}));
  end
endmodule

// File: rtl/trap_redir_target.sv
module trap_redir_target
  import trap_redir_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter logic [XLEN-1:0] DBG_ROM_ENTRY = 32'h0000_0800,
  parameter logic [XLEN-1:0] DBG_EXC_ADDR  = 32'h0000_0808
) (
  input  action_e         act_i,
  input  logic [XLEN-1:0] mtvec_i,
  output logic [XLEN-1:0] target_o
);
  always_comb begin
    unique case (act_i)
      ACT_DBG_ENTER,
      ACT_DBG_RESTART: target_o = DBG_ROM_ENTRY;
      ACT_DBG_EXC:     target_o = DBG_EXC_ADDR;
      default:         target_o = mtvec_i;
    endcase
  end
endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
  import trap_redir_pkg::*;
#(
  parameter int unsigned     XLEN          = 32,
  parameter int unsigned     CAUSE_W       = 4,
  parameter int unsigned     DCAUSE_W      = 3,
  parameter int unsigned     BRK_CAUSE     = 3,
  parameter int unsigned     EBRK_DCAUSE   = 1,
  parameter logic [XLEN-1:0] RST_PC        = '0,
  parameter logic [XLEN-1:0] DBG_ROM_ENTRY = 32'h0000_0800,
  parameter logic [XLEN-1:0] DBG_EXC_ADDR  = 32'h0000_0808
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                trap_valid_i,
  input  logic [CAUSE_W-1:0]  trap_cause_i,
  input  logic [1:0]          priv_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [XLEN-1:0]     mtvec_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic [3:0]          ebreak_en_i,
  output logic                redirect_o,
  output logic [XLEN-1:0]     next_pc_o,
  output logic                dbg_enter_o,
  output logic                normal_trap_o,
  output logic [XLEN-1:0]     dpc_o,
  output logic [1:0]          saved_priv_o,
  output logic [1:0]          priv_o,
  output logic [DCAUSE_W-1:0] dbg_cause_o
);
  action_e         act;
  logic [XLEN-1:0] target;

  trap_redir_classify #(
    .CAUSE_W  (CAUSE_W),
    .DCAUSE_W (DCAUSE_W),
    .BRK_CAUSE(BRK_CAUSE)
  ) u_classify (
    .cause_i    (trap_cause_i),
    .priv_i     (priv_i),
    .dbg_cause_i(dbg_cause_i),
    .ebreak_en_i(ebreak_en_i),
    .act_o      (act)
  );

  trap_redir_target #(
    .XLEN         (XLEN),
    .DBG_ROM_ENTRY(DBG_ROM_ENTRY),
    .DBG_EXC_ADDR (DBG_EXC_ADDR)
  ) u_target (
    .act_i   (act),
    .mtvec_i (mtvec_i),
    .target_o(target)
  );

  // strobes: one cycle per trap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      dbg_enter_o   <= 1'b0;
      normal_trap_o <= 1'b0;
    end else begin
      redirect_o    <= trap_valid_i;
      dbg_enter_o   <= trap_valid_i && (act == ACT_DBG_ENTER);
      normal_trap_o <= trap_valid_i && (act == ACT_TRAP);
    end
  end

  // held state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o    <= RST_PC;
      dpc_o        <= '0;
      saved_priv_o <= PRIV_M;
      priv_o       <= PRIV_M;
      dbg_cause_o  <= '0;
    end else if (trap_valid_i) begin
      next_pc_o <= target;
      unique case (act)
        ACT_DBG_ENTER: begin
          dpc_o        <= pc_i;
          saved_priv_o <= priv_i;
          priv_o       <= PRIV_M;
          dbg_cause_o  <= DCAUSE_W'(EBRK_DCAUSE);
        end
        ACT_TRAP: priv_o <= PRIV_M;
        default: ;
      endcase
    end
  end

  a_r8_redirect_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> redirect_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> !redirect_o && !dbg_enter_o && !normal_trap_o &&
                      $stable(next_pc_o) && $stable(dpc_o) && $stable(priv_o) &&
                      $stable(saved_priv_o) && $stable(dbg_cause_o));
  a_r2_restart_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && dbg_cause_i != '0 && trap_cause_i == CAUSE_W'(BRK_CAUSE))
      |=> next_pc_o == DBG_ROM_ENTRY);
  a_r3_dbg_exc_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && dbg_cause_i != '0 && trap_cause_i != CAUSE_W'(BRK_CAUSE))
      |=> next_pc_o == DBG_EXC_ADDR && $stable(priv_o) && $stable(dpc_o) &&
          $stable(dbg_cause_o));
  a_r4_no_strobe_in_dbg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && dbg_cause_i != '0) |=> !dbg_enter_o && !normal_trap_o);
  a_r5_entry_saves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_enter_o |-> dpc_o == $past(pc_i) && saved_priv_o == $past(priv_i) &&
                    priv_o == PRIV_M && next_pc_o == DBG_ROM_ENTRY);
  a_r7_trap_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_trap_o |-> next_pc_o == $past(mtvec_i) && priv_o == PRIV_M);
  a_r7_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dbg_enter_o, normal_trap_o}));
endmodule

// File: tb/trap_redirect_bench.sv
module trap_redirect_bench;
  localparam logic [31:0] ROM   = 32'h0000_0800;
  localparam logic [31:0] DEXC  = 32'h0000_0808;
  localparam logic [31:0] MTVEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tv = 1'b0;
  logic [3:0]  cause = '0;
  logic [1:0]  priv = 2'd3;
  logic [31:0] pc = '0;
  logic [2:0]  dcause = '0;
  logic [3:0]  en = '0;
  logic        redir, enter, norm;
  logic [31:0] npc, dpc;
  logic [1:0]  sprv, prv;
  logic [2:0]  dco;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  trap_redirect u_trap_redirect (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(tv), .trap_cause_i(cause),
    .priv_i(priv), .pc_i(pc), .mtvec_i(MTVEC), .dbg_cause_i(dcause),
    .ebreak_en_i(en), .redirect_o(redir), .next_pc_o(npc), .dbg_enter_o(enter),
    .normal_trap_o(norm), .dpc_o(dpc), .saved_priv_o(sprv), .priv_o(prv),
    .dbg_cause_o(dco)
  );

  typedef struct packed {
    logic [3:0]  cause;
    logic [1:0]  priv;
    logic [31:0] pc;
    logic [2:0]  dcause;
    logic [3:0]  en;
    logic [31:0] exp_pc;
    logic        exp_enter;
    logic        exp_norm;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 2'd3, 32'h1000, 3'd0, 4'b1000, ROM,   1'b1, 1'b0}, // R5 M enabled
    '{4'd3, 2'd0, 32'h1004, 3'd0, 4'b0001, ROM,   1'b1, 1'b0}, // R6 U bit
    '{4'd3, 2'd1, 32'h1008, 3'd0, 4'b1101, MTVEC, 1'b0, 1'b1}, // R6 S bit clear
    '{4'd3, 2'd2, 32'h100c, 3'd0, 4'b0100, ROM,   1'b1, 1'b0}, // R6 H bit
    '{4'd2, 2'd3, 32'h1010, 3'd0, 4'b1111, MTVEC, 1'b0, 1'b1}, // R7 other cause
    '{4'd3, 2'd3, 32'h1014, 3'd1, 4'b0000, ROM,   1'b0, 1'b0}, // R2
    '{4'd5, 2'd1, 32'h1018, 3'd1, 4'b1111, DEXC,  1'b0, 1'b0}, // R3
    '{4'd3, 2'd0, 32'h101c, 3'd3, 4'b1111, ROM,   1'b0, 1'b0}, // R4 priority
    '{4'd0, 2'd1, 32'h1020, 3'd0, 4'b0000, MTVEC, 1'b0, 1'b1}  // R7
  };

  logic [31:0] m_dpc;
  logic [1:0]  m_sprv, m_prv;
  logic [2:0]  m_dc;
  logic [31:0] m_npc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, npc, m_npc);
    chk(req, dpc, m_dpc);
    chk(req, 32'(sprv), 32'(m_sprv));
    chk(req, 32'(prv), 32'(m_prv));
    chk(req, 32'(dco), 32'(m_dc));
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    cause = v.cause; priv = v.priv; pc = v.pc; dcause = v.dcause; en = v.en;
    tv = 1'b1;
    @(negedge clk);
    tv = 1'b0;
    m_npc = v.exp_pc;
    if (v.exp_enter) begin
      m_dpc = v.pc; m_sprv = v.priv; m_prv = 2'd3; m_dc = 3'd1;
    end else if (v.exp_norm) begin
      m_prv = 2'd3;
    end
  endtask

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_npc = '0; m_dpc = '0; m_sprv = 2'd3; m_prv = 2'd3; m_dc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 redirect", 32'(redir), 0);
    chk("R1 enter", 32'(enter), 0);
    chk("R1 norm", 32'(norm), 0);
    chk_state("R1");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      chk("R8 redirect", 32'(redir), 1);
      chk("R5 enter", 32'(enter), 32'(VECS[i].exp_enter));
      chk("R7 norm", 32'(norm), 32'(VECS[i].exp_norm));
      chk_state("R2 R3 R5 R6 R7");
      @(negedge clk);
      chk("R8 pulse end", 32'({redir, enter, norm}), 0);
      chk_state("R8 hold");
    end

    // R8: inputs change without trap_valid_i, nothing moves
    @(negedge clk);
    cause = 4'd3; priv = 2'd3; pc = 32'hdead_beef; dcause = 3'd0; en = 4'hf;
    repeat (2) @(negedge clk);
    chk("R8 idle strobes", 32'({redir, enter, norm}), 0);
    chk_state("R8 idle");

    // back-to-back: entry, then a breakpoint while in debug (R4, R5)
    @(negedge clk);
    cause = 4'd3; priv = 2'd1; pc = 32'h2000; dcause = 3'd0; en = 4'b0010; tv = 1'b1;
    @(negedge clk);
    chk("R5 b2b enter", 32'(enter), 1);
    chk("R5 b2b dpc", dpc, 32'h2000);
    chk("R5 b2b sprv", 32'(sprv), 1);
    chk("R5 b2b dcause", 32'(dco), 1);
    pc = 32'h2004; dcause = 3'd1;
    @(negedge clk);
    tv = 1'b0;
    chk("R8 b2b redirect", 32'(redir), 1);
    chk("R4 b2b no enter", 32'(enter), 0);
    chk("R2 b2b pc", npc, ROM);
    chk("R4 b2b dpc kept", dpc, 32'h2000);

    // R1 async reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_npc = '0; m_dpc = '0; m_sprv = 2'd3; m_prv = 2'd3; m_dc = '0;
    chk_state("R1 reassert");
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule